// File: doc/BRIEF.md
# Vector Arithmetic Exception Result Encoder

This block sits at the end of a vector floating-point pipeline. Each cycle it may take one element: the raw result computed upstream, the element's data format, the exception flags the arithmetic raised, the number of the destination vector register and the instruction's exception-enable control bit. From these it decides what is written into the destination element. The choices are the raw result, a zero, or a reserved-operand pattern that carries the exception kinds inside it. The chosen word appears one clock later, together with a valid strobe and the register number.

Exceptions never halt the vector operation. Every element completes, and a faulting element is marked only through the word written for it. Alongside the data path, a sticky summary register gathers which exception kinds have been recorded. It also keeps a 16-bit mask of the destination registers that took a recorded exception. A synchronous clear input empties the summary. Format codes are F = 0, D = 1, G = 2, longword = 3. Longword is the destination of a float-to-integer conversion.

Top module: `vexc_encoder`

## Requirements
- R1: An element presented with `elem_valid` high produces `wr_valid` high exactly one clock later, with `wr_reg` equal to its `dest_reg`. A cycle with `elem_valid` low produces `wr_valid` low one clock later.
- R2: Formats D (1) and G (2) with no enabled exception and no underflow pass all 64 bits of `raw_result` unchanged to `wr_data`. Format F (0) passes bits 31:0 and drives bits 63:32 to zero.
- R3: A reserved-operand word has bit 15 set, bits 14:4 zero and all bits above 15 zero. Bits 3:0 hold the exception kinds: bit 0 underflow, bit 1 divide by zero, bit 2 overflow, bit 3 reserved operand. Several kinds may appear together, such as a reserved operand divided by zero giving 0xA.
- R4: In the float formats, overflow, divide by zero and reserved-operand flags always produce a reserved-operand word and are recorded, whatever the value of `exc_en`.
- R5: In the float formats, underflow with `exc_en` low and no other float flag gives an all-zero word and records nothing. With `exc_en` high, underflow produces a reserved-operand word with bit 0 set and is recorded.
- R6: In longword format (3), `wr_data` is always bits 31:0 of `raw_result` with bits 63:32 zero. Integer overflow is recorded only when `exc_en` is high. The overflow, underflow and divide-by-zero flags are ignored.
- R7: In longword format, a reserved-operand source is always recorded, but the word written is the truncated raw result, not a reserved-operand pattern. In the float formats, the integer-overflow flag is ignored.
- R8: A recorded exception sets the matching bit of `exc_sum` one clock after the element. Bits 0 to 3 of `exc_sum` follow the same order as the reserved-operand type field, and bit 4 is integer overflow. The same edge sets bit `dest_reg` of `exc_regmask`. Both bits stay set until cleared.
- R9: `clr_exc` zeroes `exc_sum` and `exc_regmask` on the next clock. A recording made by a valid element in the same cycle as the clear is kept.
- R10: Flags on a cycle with `elem_valid` low change neither `exc_sum` nor `exc_regmask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| elem_valid | input | 1 | Element present this cycle |
| elem_fmt | input | 2 | Format: 0 F, 1 D, 2 G, 3 longword |
| raw_result | input | 64 | Result from the arithmetic stage |
| flg_ovf | input | 1 | Floating overflow |
| flg_unf | input | 1 | Floating underflow |
| flg_dvz | input | 1 | Floating divide by zero |
| flg_rsv | input | 1 | Reserved-operand source |
| flg_iov | input | 1 | Integer overflow of a conversion |
| exc_en | input | 1 | Instruction exception-enable bit |
| dest_reg | input | 4 | Destination vector register number |
| clr_exc | input | 1 | Clear the exception summary |
| wr_valid | output | 1 | Element write strobe |
| wr_data | output | 64 | Word to write into the element |
| wr_reg | output | 4 | Destination register of the write |
| exc_sum | output | 5 | Sticky exception kinds |
| exc_regmask | output | 16 | Sticky destination register mask |

## Verification
The hardest cases to reach are the ones where the status and data paths disagree. One is a longword element with a reserved-operand source, which is recorded yet written as a plain truncated value. Another is a clear that coincides with a new recording, where the summary must drop its history and keep the new entry. Random flags on all four formats cover the first case often, and a directed sequence first fills the summary and then clears it while a faulting element arrives. Further directed steps drive flags with the valid strobe low, and combine reserved operand with divide by zero so that the two type bits appear together.

// File: rtl/vexc_pkg.sv
package vexc_pkg;

    localparam int ELEM_W    = 64;
    localparam int WORD_W    = 32;
    localparam int ETYPE_W   = 4;
    localparam int NUM_KIND  = 5;
    localparam int SIGN_BIT  = 15;

    localparam int K_UNF = 0;
    localparam int K_DVZ = 1;
    localparam int K_OVF = 2;
    localparam int K_RSV = 3;
    localparam int K_IOV = 4;

    typedef enum logic [1:0] {
        FMT_F = 2'd0,
        FMT_D = 2'd1,
        FMT_G = 2'd2,
        FMT_L = 2'd3
    } elem_fmt_e;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'd0,
        ACT_ZERO  = 2'd1,
        ACT_RESOP = 2'd2
    } wr_action_e;

    typedef struct packed {
        logic iov;
        logic rsv;
        logic ovf;
        logic dvz;
        logic unf;
    } exc_flags_t;

    typedef struct packed {
        wr_action_e            act;
        logic [ETYPE_W-1:0]    etype;
        logic [NUM_KIND-1:0]   rec;
    } elem_decision_t;

    function automatic logic [ELEM_W-1:0] resop_word(input logic [ETYPE_W-1:0] et);
        logic [ELEM_W-1:0] w;
        w = '0;
        w[SIGN_BIT] = 1'b1;
        w[ETYPE_W-1:0] = et;
        return w;
    endfunction

    function automatic logic [ELEM_W-1:0] low_word(input logic [ELEM_W-1:0] v);
        return {{(ELEM_W-WORD_W){1'b0}}, v[WORD_W-1:0]};
    endfunction

endpackage

// File: rtl/vexc_classify.sv
module vexc_classify
    import vexc_pkg::*;
(
    input  elem_fmt_e       fmt,
    input  exc_flags_t      flags,
    input  logic            exc_en,
    output elem_decision_t  dec
);
    logic [ETYPE_W-1:0] fl_et;

    always_comb begin
        fl_et        = '0;
        fl_et[K_UNF] = flags.unf & exc_en;
        fl_et[K_DVZ] = flags.dvz;
        fl_et[K_OVF] = flags.ovf;
        fl_et[K_RSV] = flags.rsv;

        dec = '{act: ACT_PASS, etype: '0, rec: '0};
        if (fmt == FMT_L) begin
            dec.rec[K_RSV] = flags.rsv;
            dec.rec[K_IOV] = flags.iov & exc_en;
        end else if (fl_et != '0) begin
            dec.act             = ACT_RESOP;
            dec.etype           = fl_et;
            dec.rec[ETYPE_W-1:0] = fl_et;
        end else if (flags.unf) begin
            dec.act = ACT_ZERO;
        end
    end
endmodule

// File: rtl/vexc_result_mux.sv
module vexc_result_mux
    import vexc_pkg::*;
(
    input  elem_fmt_e          fmt,
    input  logic [ELEM_W-1:0]  raw,
    input  elem_decision_t     dec,
    output logic [ELEM_W-1:0]  word
);
    logic narrow;
    assign narrow = (fmt == FMT_F) || (fmt == FMT_L);

    always_comb begin
        unique case (dec.act)
            ACT_RESOP: word = resop_word(dec.etype);
            ACT_ZERO:  word = '0;
            default:   word = narrow ? low_word(raw) : raw;
        endcase
    end
endmodule

// File: rtl/vexc_status.sv
module vexc_status
    import vexc_pkg::*;
#(
    parameter int NUM_VREG = 16,
    localparam int IDX_W   = $clog2(NUM_VREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 hit,
    input  logic [NUM_KIND-1:0]  kinds,
    input  logic [IDX_W-1:0]     dest,
    output logic [NUM_KIND-1:0]  sum,
    output logic [NUM_VREG-1:0]  regmask
);
    logic any;
    assign any = hit && (kinds != '0);

    always_ff @(posedge clk) begin
        if (rst)
            sum <= '0;
        else
            sum <= (clr ? '0 : sum) | (hit ? kinds : '0);
    end

    for (genvar g = 0; g < NUM_VREG; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                regmask[g] <= 1'b0;
            else
                regmask[g] <= (regmask[g] & ~clr) | (any && (dest == IDX_W'(g)));
        end
    end
endmodule

// File: rtl/vexc_encoder.sv
module vexc_encoder
    import vexc_pkg::*;
#(
    parameter int NUM_VREG = 16,
    localparam int IDX_W   = $clog2(NUM_VREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 elem_valid,
    input  logic [1:0]           elem_fmt,
    input  logic [ELEM_W-1:0]    raw_result,
    input  logic                 flg_ovf,
    input  logic                 flg_unf,
    input  logic                 flg_dvz,
    input  logic                 flg_rsv,
    input  logic                 flg_iov,
    input  logic                 exc_en,
    input  logic [IDX_W-1:0]     dest_reg,
    input  logic                 clr_exc,
    output logic                 wr_valid,
    output logic [ELEM_W-1:0]    wr_data,
    output logic [IDX_W-1:0]     wr_reg,
    output logic [NUM_KIND-1:0]  exc_sum,
    output logic [NUM_VREG-1:0]  exc_regmask
);
    elem_fmt_e         fmt;
    exc_flags_t        flags;
    elem_decision_t    dec;
    logic [ELEM_W-1:0] word;

    assign fmt   = elem_fmt_e'(elem_fmt);
    assign flags = '{iov: flg_iov, rsv: flg_rsv, ovf: flg_ovf, dvz: flg_dvz, unf: flg_unf};

    vexc_classify u_classify (
        .fmt    (fmt),
        .flags  (flags),
        .exc_en (exc_en),
        .dec    (dec)
    );

    vexc_result_mux u_mux (
        .fmt  (fmt),
        .raw  (raw_result),
        .dec  (dec),
        .word (word)
    );

    vexc_status #(.NUM_VREG(NUM_VREG)) u_status (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_exc),
        .hit     (elem_valid),
        .kinds   (dec.rec),
        .dest    (dest_reg),
        .sum     (exc_sum),
        .regmask (exc_regmask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
            wr_reg   <= '0;
        end else begin
            wr_valid <= elem_valid;
            if (elem_valid) begin
                wr_data <= word;
                wr_reg  <= dest_reg;
            end
        end
    end
endmodule

// File: rtl/vexc_encoder_chk.sv
module vexc_encoder_chk
    import vexc_pkg::*;
#(
    parameter int NUM_VREG = 16,
    localparam int IDX_W   = $clog2(NUM_VREG)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 elem_valid,
    input logic [1:0]           elem_fmt,
    input logic                 flg_ovf,
    input logic                 flg_unf,
    input logic                 flg_dvz,
    input logic                 flg_rsv,
    input logic                 exc_en,
    input logic                 clr_exc,
    input logic                 wr_valid,
    input logic [ELEM_W-1:0]    wr_data,
    input logic [NUM_KIND-1:0]  exc_sum,
    input logic [NUM_VREG-1:0]  exc_regmask
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        elem_valid |=> wr_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !elem_valid |=> !wr_valid);

    a_r2_f_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (elem_valid && elem_fmt == 2'd0) |=> (wr_data[63:32] == 32'd0));

    a_r4_ovf_resop: assert property (@(posedge clk) disable iff (rst)
        (elem_valid && elem_fmt != 2'd3 && flg_ovf) |=>
            (wr_data[15] && wr_data[14:4] == 11'd0 && wr_data[2] && exc_sum[2]));

    a_r5_quiet_underflow: assert property (@(posedge clk) disable iff (rst)
        (elem_valid && elem_fmt != 2'd3 && flg_unf && !exc_en && !flg_ovf
         && !flg_dvz && !flg_rsv && !clr_exc) |=>
            (wr_data == '0 && $stable(exc_sum) && $stable(exc_regmask)));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_exc |=> ((exc_sum & $past(exc_sum)) == $past(exc_sum)));

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_exc && !elem_valid) |=> (exc_sum == '0 && exc_regmask == '0));

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!elem_valid && !clr_exc) |=> ($stable(exc_sum) && $stable(exc_regmask)));
endmodule

bind vexc_encoder vexc_encoder_chk #(.NUM_VREG(NUM_VREG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .elem_valid  (elem_valid),
    .elem_fmt    (elem_fmt),
    .flg_ovf     (flg_ovf),
    .flg_unf     (flg_unf),
    .flg_dvz     (flg_dvz),
    .flg_rsv     (flg_rsv),
    .exc_en      (exc_en),
    .clr_exc     (clr_exc),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .exc_sum     (exc_sum),
    .exc_regmask (exc_regmask)
);

// File: tb/vexc_encoder_bench.sv
module vexc_encoder_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        elem_valid;
    logic [1:0]  elem_fmt;
    logic [63:0] raw_result;
    logic        flg_ovf, flg_unf, flg_dvz, flg_rsv, flg_iov;
    logic        exc_en;
    logic [3:0]  dest_reg;
    logic        clr_exc;
    logic        wr_valid;
    logic [63:0] wr_data;
    logic [3:0]  wr_reg;
    logic [4:0]  exc_sum;
    logic [15:0] exc_regmask;

    int n_vec  = 0;
    int n_fail = 0;
    logic [4:0]  m_sum;
    logic [15:0] m_mask;

    always #10 clk = ~clk;

    vexc_encoder u_vexc_encoder (
        .clk(clk), .rst(rst), .elem_valid(elem_valid), .elem_fmt(elem_fmt),
        .raw_result(raw_result), .flg_ovf(flg_ovf), .flg_unf(flg_unf),
        .flg_dvz(flg_dvz), .flg_rsv(flg_rsv), .flg_iov(flg_iov),
        .exc_en(exc_en), .dest_reg(dest_reg), .clr_exc(clr_exc),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_reg(wr_reg),
        .exc_sum(exc_sum), .exc_regmask(exc_regmask)
    );

    function automatic logic [63:0] want_data(input logic [1:0] f, input logic [63:0] r,
        input logic ov, input logic un, input logic dz, input logic rs, input logic en);
        logic [3:0] et;
        if (f == 2'd3) return {32'd0, r[31:0]};
        et = {rs, ov, dz, un & en};
        if (et != 4'd0) return {48'd0, 1'b1, 11'd0, et};
        if (un) return 64'd0;
        if (f == 2'd0) return {32'd0, r[31:0]};
        return r;
    endfunction

    function automatic logic [4:0] want_rec(input logic [1:0] f, input logic ov,
        input logic un, input logic dz, input logic rs, input logic io, input logic en);
        if (f == 2'd3) return {io & en, rs, 3'b000};
        return {1'b0, rs, ov, dz, un & en};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        elem_valid = 0; elem_fmt = 0; raw_result = 0;
        flg_ovf = 0; flg_unf = 0; flg_dvz = 0; flg_rsv = 0; flg_iov = 0;
        exc_en = 0; dest_reg = 0; clr_exc = 0;
    endtask

    // Drive one cycle at a negedge, check the result at the following negedge.
    task automatic apply(input logic v, input logic [1:0] f, input logic [63:0] r,
        input logic ov, input logic un, input logic dz, input logic rs, input logic io,
        input logic en, input logic [3:0] d, input logic clr, input string req);
        logic [4:0] rec;
        @(negedge clk);
        elem_valid = v; elem_fmt = f; raw_result = r;
        flg_ovf = ov; flg_unf = un; flg_dvz = dz; flg_rsv = rs; flg_iov = io;
        exc_en = en; dest_reg = d; clr_exc = clr;
        rec = want_rec(f, ov, un, dz, rs, io, en);
        if (clr) begin m_sum = '0; m_mask = '0; end
        if (v) begin
            m_sum = m_sum | rec;
            if (rec != 5'd0) m_mask[d] = 1'b1;
        end
        @(negedge clk);
        idle_inputs();
        check({req, " R1 valid"}, {63'd0, wr_valid}, {63'd0, v});
        if (v) begin
            check({req, " data"}, wr_data, want_data(f, r, ov, un, dz, rs, en));
            check("R1 reg", {60'd0, wr_reg}, {60'd0, d});
        end
        check({req, " R8 sum"}, {59'd0, exc_sum}, {59'd0, m_sum});
        check({req, " R8 mask"}, {48'd0, exc_regmask}, {48'd0, m_mask});
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] r;
        int seed;
        idle_inputs();
        m_sum = '0; m_mask = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("reset R1 wr_valid", {63'd0, wr_valid}, 64'd0);
        check("reset R8 exc_sum", {59'd0, exc_sum}, 64'd0);
        check("reset R8 exc_regmask", {48'd0, exc_regmask}, 64'd0);

        r = 64'hDEAD_BEEF_1234_5678;
        apply(1, 2'd1, r, 0,0,0,0,0, 0, 4'd1, 0, "R2 D pass");
        apply(1, 2'd2, r, 0,0,0,0,0, 1, 4'd2, 0, "R2 G pass");
        apply(1, 2'd0, r, 0,0,0,0,0, 0, 4'd3, 0, "R2 F narrow");
        apply(1, 2'd0, r, 0,1,0,0,0, 0, 4'd4, 0, "R5 quiet underflow");
        apply(1, 2'd1, r, 0,1,0,0,0, 1, 4'd5, 0, "R5 enabled underflow");
        apply(1, 2'd2, r, 0,0,1,1,0, 0, 4'd6, 0, "R3 rsv plus dvz");
        apply(1, 2'd0, r, 1,0,0,0,0, 0, 4'd7, 0, "R4 overflow forced");
        apply(1, 2'd3, r, 1,1,1,0,1, 0, 4'd8, 0, "R6 iov disabled");
        apply(1, 2'd3, r, 0,0,0,0,1, 1, 4'd9, 0, "R6 iov enabled");
        apply(1, 2'd3, r, 0,0,0,1,0, 0, 4'd10, 0, "R7 longword rsv source");
        apply(1, 2'd1, r, 0,0,0,0,1, 1, 4'd11, 0, "R7 iov ignored in float");
        apply(0, 2'd0, r, 1,1,1,1,1, 1, 4'd12, 0, "R10 idle flags");
        apply(1, 2'd0, r, 0,0,1,0,0, 0, 4'd13, 1, "R9 clear with record");
        apply(0, 2'd0, r, 0,0,0,0,0, 0, 4'd0, 1, "R9 clear alone");

        seed = 32'h1357_9BDF;
        void'($urandom(seed));
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] rr;
            rr = {$urandom(), $urandom()};
            apply(($urandom() % 8) != 0, 2'($urandom()), rr,
                  ($urandom() % 5) == 0, ($urandom() % 4) == 0,
                  ($urandom() % 6) == 0, ($urandom() % 6) == 0,
                  ($urandom() % 4) == 0, 1'($urandom()),
                  4'($urandom()), ($urandom() % 40) == 0, "R3 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule